// File: doc/BRIEF.md
# Sleep Mode Entry and Exit Controller

This block sequences a synchronous memory front end into and out of a low-power sleep state. A sleep request arrives without any timing relation to the clock. The block brings it into the clock domain and then steps through a fixed entry phase and a fixed exit phase, each two cycles long. After waking, it holds a two-cycle recovery window before accesses are allowed again. The array is assumed to keep its contents throughout. The block only stops traffic from reaching it.

While the controller is entering, asleep, exiting or recovering, it asserts an inhibit output. The memory datapath uses this to block reads and writes. Read-valid indications from the array are gated off during that time, so an access that is still in flight when sleep begins is never reported as valid. The controller emits a one-cycle pulse when such an access is abandoned. It raises a one-cycle violation flag in two cases: when sleep is requested while any chip enable is active, and when a chip enable goes active during the recovery window.

Top module: `sleep_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `core_sleep`, `access_inhibit`, `pend_dropped` and `violation` are all 0. `rd_valid_out` follows `rd_valid_in`.
- R2: `sleep_req` passes through two synchronizer flops. A request held from before clock edge 1 raises `access_inhibit` after edge 3 and `core_sleep` after edge 5.
- R3: A deassertion held from before edge 1 lowers `core_sleep` after edge 5. `access_inhibit` stays high for two more cycles and falls after edge 7.
- R4: `rd_valid_out` equals `rd_valid_in` when `access_inhibit` is 0, and is 0 whenever `access_inhibit` is 1.
- R5: If `access_pending` is 1 at the edge where the controller leaves the awake state, `pend_dropped` is 1 for exactly the following cycle. Otherwise it stays 0.
- R6: If the synchronized request is high in the awake state while any bit of `ce_on` is 1, `violation` is 1 for the following cycle. Entry still proceeds. A chip enable that is active with no request pending raises no violation.
- R7: Any bit of `ce_on` at 1 at an edge during the recovery window sets `violation` for the following cycle.
- R8: Chip enables seen while fully asleep have no effect: no violation, and sleep is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| ce_on | input | NCE | Chip enables, active high; any bit set means selected |
| access_pending | input | 1 | An access is in flight in the datapath |
| rd_valid_in | input | 1 | Read-valid from the array |
| rd_valid_out | output | 1 | Read-valid gated by the inhibit |
| core_sleep | output | 1 | Array is in sleep |
| access_inhibit | output | 1 | Blocks all reads and writes |
| pend_dropped | output | 1 | One-cycle pulse: an in-flight access was abandoned |
| violation | output | 1 | One-cycle pulse: deselect or recovery rule broken |

## Verification
The recovery window is the hardest condition to reach from the ports. It lasts only two cycles, and it begins five edges after the request is deasserted, behind the synchronizer and the exit phase. The stimulus counts edges from the deassertion and raises a chip enable in the first recovery cycle. It then drops the enable again, to show that the flag is a single pulse and that the window closes on time. A chip enable raised while fully asleep serves as the contrasting case, where no flag may appear.

// File: rtl/sleep_ctl.sv
module sleep_ctl #(
  parameter int NCE       = 3,
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int RECOV_CYC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sleep_req,
  input  logic [NCE-1:0] ce_on,
  input  logic           access_pending,
  input  logic           rd_valid_in,
  output logic           rd_valid_out,
  output logic           core_sleep,
  output logic           access_inhibit,
  output logic           pend_dropped,
  output logic           violation
);
  localparam int M1   = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int MAXC = (M1 > RECOV_CYC) ? M1 : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {AWAKE, ENTER, ASLEEP, LEAVE, RECOVER} st_t;

  st_t           st, st_nx;
  logic          req_m, req_s;
  logic [CW-1:0] cnt;
  logic          sel, done;

  assign sel = |ce_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {req_m, req_s} <= 2'b00;
    else        {req_m, req_s} <= {sleep_req, req_m};

  always_comb begin
    case (st)
      ENTER:   done = (cnt == CW'(ENTRY_CYC - 1));
      LEAVE:   done = (cnt == CW'(EXIT_CYC - 1));
      RECOVER: done = (cnt == CW'(RECOV_CYC - 1));
      default: done = 1'b0;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      AWAKE:   if (req_s)  st_nx = ENTER;
      ENTER:   if (done)   st_nx = ASLEEP;
      ASLEEP:  if (!req_s) st_nx = LEAVE;
      LEAVE:   if (done)   st_nx = RECOVER;
      RECOVER: if (done)   st_nx = AWAKE;
      default:             st_nx = AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st           <= AWAKE;
      cnt          <= '0;
      pend_dropped <= 1'b0;
      violation    <= 1'b0;
    end else begin
      st           <= st_nx;
      cnt          <= (st_nx != st) ? '0 : cnt + 1'b1;
      pend_dropped <= (st == AWAKE) && req_s && access_pending;
      violation    <= sel && (((st == AWAKE) && req_s) || (st == RECOVER));
    end

  assign core_sleep     = (st == ASLEEP) || (st == LEAVE);
  assign access_inhibit = (st != AWAKE);
  assign rd_valid_out   = rd_valid_in && !access_inhibit;
endmodule

module sleep_ctl_chk #(
  parameter int NCE = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCE-1:0] ce_on,
  input logic           rd_valid_out,
  input logic           core_sleep,
  input logic           access_inhibit,
  input logic           pend_dropped,
  input logic           violation
);
  // R4
  sleep_gates_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_sleep |-> access_inhibit);

  // R4
  no_valid_when_inhibited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_inhibit |-> !rd_valid_out);

  // R2
  entry_two_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_sleep) |-> ($past(access_inhibit) && $past(access_inhibit, 2)));

  // R3
  recovery_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_sleep) |=> access_inhibit);

  // R5
  drop_on_entry_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_dropped |-> $rose(access_inhibit));

  // R7
  violation_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> (|$past(ce_on)));
endmodule

bind sleep_ctl sleep_ctl_chk #(.NCE(NCE)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_on(ce_on), .rd_valid_out(rd_valid_out),
  .core_sleep(core_sleep), .access_inhibit(access_inhibit),
  .pend_dropped(pend_dropped), .violation(violation)
);

// File: tb/sleep_ctl_tb_top.sv
module sleep_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic [2:0] ce_on = '0;
  logic       access_pending = 1'b0;
  logic       rd_valid_in = 1'b0;
  logic       rd_valid_out, core_sleep, access_inhibit, pend_dropped, violation;

  int errors = 0;
  int checks = 0;
  bit ended  = 1'b0;

  typedef struct {
    logic  sl, inh, vi, dr, rv;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  sleep_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ce_on(ce_on),
    .access_pending(access_pending), .rd_valid_in(rd_valid_in),
    .rd_valid_out(rd_valid_out), .core_sleep(core_sleep),
    .access_inhibit(access_inhibit), .pend_dropped(pend_dropped),
    .violation(violation)
  );

  task automatic compare(exp_t e);
    checks++;
    if ({core_sleep, access_inhibit, violation, pend_dropped, rd_valid_out} !==
        {e.sl, e.inh, e.vi, e.dr, e.rv}) begin
      errors++;
      $display("FAIL %s: got sleep/inh/viol/drop/rv=%b%b%b%b%b expected %b%b%b%b%b",
               e.tag, core_sleep, access_inhibit, violation, pend_dropped, rd_valid_out,
               e.sl, e.inh, e.vi, e.dr, e.rv);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic step(logic req, logic [2:0] ce, logic pend, logic rv,
                      logic sl, logic inh, logic vi, logic dr, logic rvo, string tag);
    exp_t e;
    @(negedge clk);
    sleep_req = req; ce_on = ce; access_pending = pend; rd_valid_in = rv;
    e.sl = sl; e.inh = inh; e.vi = vi; e.dr = dr; e.rv = rvo; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got hung run expected completion");
    summary();
  end

  initial begin
    exp_t r;
    sleep_req = 1'b1; rd_valid_in = 1'b1; access_pending = 1'b1; ce_on = 3'b111;
    repeat (3) @(posedge clk);
    #2;
    r.sl = 0; r.inh = 0; r.vi = 0; r.dr = 0; r.rv = 1; r.tag = "R1 in reset";
    compare(r);
    @(negedge clk);
    sleep_req = 0; ce_on = 0; access_pending = 0;
    rst_n = 1'b1;
    step(0, 3'b000, 0, 1, 0, 0, 0, 0, 1, "R1 after release");
    // a selected device without a request pending is not a violation
    step(0, 3'b111, 0, 1, 0, 0, 0, 0, 1, "R6 selected no request");
    step(0, 3'b000, 0, 0, 0, 0, 0, 0, 0, "R4 passthrough low");

    // clean entry: deselected, nothing pending
    step(1, 3'b000, 0, 1, 0, 0, 0, 0, 1, "R2 edge1");
    step(1, 3'b000, 0, 1, 0, 0, 0, 0, 1, "R2 edge2");
    step(1, 3'b000, 0, 1, 0, 1, 0, 0, 0, "R2 R5 inhibit edge3 no drop");
    step(1, 3'b000, 0, 1, 0, 1, 0, 0, 0, "R4 entering");
    step(1, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R2 asleep edge5");
    step(1, 3'b010, 0, 1, 1, 1, 0, 0, 0, "R8 ce while asleep");
    step(1, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R8 no violation");
    // exit
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit edge1");
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit edge2");
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit edge3");
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit edge4");
    step(0, 3'b000, 0, 1, 0, 1, 0, 0, 0, "R3 wake edge5");
    step(0, 3'b000, 0, 1, 0, 1, 0, 0, 0, "R3 recovery edge6");
    step(0, 3'b000, 0, 1, 0, 0, 0, 0, 1, "R3 R4 awake edge7");

    // entry while selected with an access pending
    step(1, 3'b001, 1, 1, 0, 0, 0, 0, 1, "R6 edge1");
    step(1, 3'b001, 1, 1, 0, 0, 0, 0, 1, "R6 edge2");
    step(1, 3'b001, 1, 1, 0, 1, 1, 1, 0, "R5 R6 flags edge3");
    step(1, 3'b000, 0, 1, 0, 1, 0, 0, 0, "R5 R6 pulse cleared");
    step(1, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R2 asleep again");
    // exit with an enable during recovery
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit2 edge1");
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit2 edge2");
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit2 edge3");
    step(0, 3'b000, 0, 1, 1, 1, 0, 0, 0, "R3 exit2 edge4");
    step(0, 3'b000, 0, 1, 0, 1, 0, 0, 0, "R3 exit2 edge5");
    step(0, 3'b100, 0, 1, 0, 1, 1, 0, 0, "R7 ce in recovery");
    step(0, 3'b000, 0, 1, 0, 0, 0, 0, 1, "R7 window closed");
    step(0, 3'b100, 0, 1, 0, 0, 0, 0, 1, "R7 no flag when awake");
    step(0, 3'b000, 0, 1, 0, 0, 0, 0, 1, "R6 idle");

    repeat (3) @(posedge clk);
    #3;
    summary();
  end
endmodule